// File: doc/BRIEF.md
# I2C Target Front End for an 8-bit Port Expander

This block is the bus-facing half of an 8-bit port expander. It watches already-filtered SCL and SDA samples, recognizes START, repeated START and STOP, and answers only to its own 7-bit target address. That address is a fixed upper nibble followed by three strap inputs. The block acknowledges bytes by pulling SDA low and shifts read data out on SDA.

In a write transaction, the first byte after the address is a command byte. It is kept in a pointer register that software cannot read. Any further bytes in the same write go to the register the pointer names, as one-cycle write strobes. A read transaction fetches the pointed register with a one-cycle read strobe. It then shifts that byte out and fetches the same register again for every byte the controller acknowledges.

The register file sits outside the block. It decodes a small select field and must return read data combinationally in the cycle of the read strobe.

Top module: `i2c_port_target`

## Requirements
- R1: The block acknowledges an address byte, by driving SDA low during the ninth SCL pulse, only when the first seven bits equal binary 0100 followed by strap bits 2, 1 and 0 in that order. For any other address it never drives SDA and issues no strobe until the next START.
- R2: The eighth bit of the address byte selects the direction: 1 is a read and 0 is a write. A write transaction never produces a read strobe.
- R3: In a write, the byte after the address is acknowledged and stored as the command pointer. The pointer is kept after STOP and is never returned as read data.
- R4: Each data byte after the command byte in a write is acknowledged. It raises `reg_wr_o` for exactly one clock while SCL is low, with `reg_sel_o` equal to pointer bits 1:0 and `reg_wdata_o` equal to the byte. Consecutive bytes go to the same register.
- R5: Command 00h selects the input register, which is read only. Data bytes written with this pointer are acknowledged and produce no write strobe.
- R6: A read returns the selected register MSB first. Select codes are 00h input, 01h output, 02h polarity inversion and 03h configuration. `reg_rd_o` pulses for one clock while SCL is low, before the first bit is driven.
- R7: A repeated START followed by a read uses the pointer written just before it.
- R8: While the controller acknowledges read bytes, the pointer does not advance. Each further byte issues a fresh read strobe for the same register.
- R9: After the controller NACKs a read byte, SDA stays released and no strobe occurs until STOP or START.
- R10: A command byte with any of bits 7:2 set is acknowledged but selects nothing. Writes through it produce no strobe, and reads return 00h with no read strobe.
- R11: During and right after reset, SDA is released and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Filtered SCL level |
| sda_i | input | 1 | Filtered SDA level (wired bus value) |
| strap_i | input | 3 | Address strap levels, bit 2 first on the bus |
| sda_drive_low_o | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_sel_o | output | 2 | Register select from the pointer |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_wdata_o | output | 8 | Write data |
| reg_rd_o | output | 1 | One-cycle register read strobe |
| reg_rdata_i | input | 8 | Read data, valid in the strobe cycle |

## Verification
Each of the four legal commands is tried, together with out-of-range commands that have a high bit set or a low-bit pattern above the register count. Write-then-read pairs use bytes whose bit-reversed value differs, so a swapped shift order shows up, and the writable registers get distinct values, so a wrong select shows up. Wrong addresses differ either in a strap bit or in the fixed nibble, which tells the two halves of the match apart. Multi-byte writes, reads with acknowledged follow-on bytes, and clocks sent after a NACK show whether the pointer is kept and whether the block goes quiet.

// File: rtl/i2c_port_pkg.sv
package i2c_port_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ACK_ADDR,
      ST_CMD,
      ST_ACK_CMD,
      ST_WDATA,
      ST_ACK_WR,
      ST_TX,
      ST_MACK,
      ST_WAIT
   } tgt_state_e;

   typedef struct packed {
      logic start;
      logic stop;
      logic scl_rise;
      logic scl_fall;
      logic sda_lvl;
   } line_ev_t;

endpackage

// File: rtl/i2c_line_events.sv
module i2c_line_events
   import i2c_port_pkg::*;
#(
   parameter bit EXTRA_SYNC = 1'b0
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_i,
   input  logic     sda_i,
   output line_ev_t ev,
   output logic     scl_lvl
);

   logic scl_s, sda_s;
   logic scl_q, sda_q, scl_p, sda_p;

   generate
      if (EXTRA_SYNC) begin : g_pre
         logic scl_r, sda_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               scl_r <= 1'b1;
               sda_r <= 1'b1;
            end else begin
               scl_r <= scl_i;
               sda_r <= sda_i;
            end
         end
         assign scl_s = scl_r;
         assign sda_s = sda_r;
      end else begin : g_direct
         assign scl_s = scl_i;
         assign sda_s = sda_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
         scl_p <= scl_q;
         sda_p <= sda_q;
      end
   end

   always_comb begin
      ev.start    = scl_q & scl_p & sda_p & ~sda_q;
      ev.stop     = scl_q & scl_p & ~sda_p & sda_q;
      ev.scl_rise = scl_q & ~scl_p;
      ev.scl_fall = ~scl_q & scl_p;
      ev.sda_lvl  = sda_q;
   end

   assign scl_lvl = scl_q;

endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
   parameter int ADDR_W  = 7,
   parameter int STRAP_W = 3,
   parameter logic [ADDR_W-STRAP_W-1:0] ADDR_PREFIX = 4'b0100
) (
   input  logic [ADDR_W-1:0]  rx_addr,
   input  logic [STRAP_W-1:0] strap,
   output logic               hit
);

   localparam int FIX_W = ADDR_W - STRAP_W;

   logic [ADDR_W-1:0] expect_addr;
   logic [ADDR_W-1:0] bit_eq;

   assign expect_addr = {ADDR_PREFIX, strap};

   generate
      for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
         assign bit_eq[b] = (rx_addr[b] == expect_addr[b]);
      end
   endgenerate

   assign hit = &bit_eq;

   initial begin
      if (FIX_W < 1) $fatal(1, "address prefix must be at least one bit");
   end

endmodule

// File: rtl/i2c_reg_decode.sv
module i2c_reg_decode #(
   parameter int DATA_W    = 8,
   parameter int REG_COUNT = 4,
   parameter int RO_IDX    = 0,
   localparam int SEL_W    = $clog2(REG_COUNT)
) (
   input  logic [DATA_W-1:0] ptr,
   output logic [SEL_W-1:0]  sel,
   output logic              rd_ok,
   output logic              wr_ok
);

   logic upper_zero;

   assign sel        = ptr[SEL_W-1:0];
   assign upper_zero = (ptr[DATA_W-1:SEL_W] == '0);

   generate
      if (REG_COUNT == (1 << SEL_W)) begin : g_pow2
         assign rd_ok = upper_zero;
      end else begin : g_partial
         assign rd_ok = upper_zero && (int'(sel) < REG_COUNT);
      end
   endgenerate

   assign wr_ok = rd_ok && (int'(sel) != RO_IDX);

   initial begin
      if (REG_COUNT < 2) $fatal(1, "need at least two registers");
      if (SEL_W >= DATA_W) $fatal(1, "select field must fit in the command byte");
      if (RO_IDX >= REG_COUNT) $fatal(1, "read-only index out of range");
   end

endmodule

// File: rtl/i2c_port_ctrl.sv
module i2c_port_ctrl
   import i2c_port_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  line_ev_t          ev,
   input  logic              addr_hit,
   input  logic              ptr_rd_ok,
   input  logic              ptr_wr_ok,
   input  logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] rx_byte,
   output logic [DATA_W-1:0] ptr_q,
   output logic              rd_stb,
   output logic              wr_stb,
   output logic              sda_low
);

   localparam int CNT_W = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

   tgt_state_e        state;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] sh, tx;
   logic              rw, more;
   logic              byte_done, load_tx;
   logic [DATA_W-1:0] tx_next;

   assign byte_done = ev.scl_fall && (cnt == LAST_BIT);
   assign load_tx   = ev.scl_fall &&
                      (((state == ST_ACK_ADDR) && rw) || ((state == ST_MACK) && more));
   assign tx_next   = ptr_rd_ok ? rd_data : '0;

   assign rd_stb = load_tx && ptr_rd_ok;
   assign wr_stb = (state == ST_WDATA) && byte_done && ptr_wr_ok;

   always_comb begin
      case (state)
         ST_ACK_ADDR, ST_ACK_CMD, ST_ACK_WR: sda_low = 1'b1;
         ST_TX:                             sda_low = ~tx[DATA_W-1];
         default:                           sda_low = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
         sh    <= '0;
         tx    <= '0;
         ptr_q <= '0;
         rw    <= 1'b0;
         more  <= 1'b0;
      end else if (ev.stop) begin
         state <= ST_IDLE;
      end else if (ev.start) begin
         state <= ST_ADDR;
         cnt   <= '0;
      end else begin
         case (state)
            ST_ADDR, ST_CMD, ST_WDATA: begin
               if (ev.scl_rise) begin
                  sh  <= {sh[DATA_W-2:0], ev.sda_lvl};
                  cnt <= cnt + 1'b1;
               end else if (byte_done) begin
                  cnt <= '0;
                  if (state == ST_ADDR) begin
                     if (addr_hit) begin
                        rw    <= sh[0];
                        state <= ST_ACK_ADDR;
                     end else begin
                        state <= ST_WAIT;
                     end
                  end else if (state == ST_CMD) begin
                     ptr_q <= sh;
                     state <= ST_ACK_CMD;
                  end else begin
                     state <= ST_ACK_WR;
                  end
               end
            end
            ST_ACK_ADDR: begin
               if (ev.scl_fall) begin
                  cnt <= '0;
                  if (rw) begin
                     tx    <= tx_next;
                     state <= ST_TX;
                  end else begin
                     state <= ST_CMD;
                  end
               end
            end
            ST_ACK_CMD, ST_ACK_WR: begin
               if (ev.scl_fall) begin
                  cnt   <= '0;
                  state <= ST_WDATA;
               end
            end
            ST_TX: begin
               if (ev.scl_rise) begin
                  cnt <= cnt + 1'b1;
               end else if (ev.scl_fall) begin
                  if (cnt == LAST_BIT) state <= ST_MACK;
                  else                 tx    <= {tx[DATA_W-2:0], 1'b0};
               end
            end
            ST_MACK: begin
               if (ev.scl_rise) begin
                  more <= ~ev.sda_lvl;
               end else if (ev.scl_fall) begin
                  if (more) begin
                     tx    <= tx_next;
                     cnt   <= '0;
                     state <= ST_TX;
                  end else begin
                     state <= ST_WAIT;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign rx_byte = sh;

endmodule

// File: rtl/i2c_port_target.sv
module i2c_port_target
   import i2c_port_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 7,
   parameter int STRAP_W   = 3,
   parameter logic [ADDR_W-STRAP_W-1:0] ADDR_PREFIX = 4'b0100,
   parameter int REG_COUNT = 4,
   parameter int RO_IDX    = 0,
   parameter bit EXTRA_SYNC = 1'b0,
   localparam int SEL_W    = $clog2(REG_COUNT)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               scl_i,
   input  logic               sda_i,
   input  logic [STRAP_W-1:0] strap_i,
   output logic               sda_drive_low_o,
   output logic [SEL_W-1:0]   reg_sel_o,
   output logic               reg_wr_o,
   output logic [DATA_W-1:0]  reg_wdata_o,
   output logic               reg_rd_o,
   input  logic [DATA_W-1:0]  reg_rdata_i
);

   line_ev_t          line_ev;
   logic              scl_lvl;
   logic              addr_hit, ptr_rd_ok, ptr_wr_ok;
   logic [DATA_W-1:0] rx_byte, cmd_ptr;

   initial begin
      if (ADDR_W + 1 != DATA_W) $fatal(1, "address plus direction bit must fill one byte");
   end

   i2c_line_events #(.EXTRA_SYNC(EXTRA_SYNC)) u_events (
      .clk     (clk),
      .rst_n   (rst_n),
      .scl_i   (scl_i),
      .sda_i   (sda_i),
      .ev      (line_ev),
      .scl_lvl (scl_lvl)
   );

   i2c_addr_match #(
      .ADDR_W      (ADDR_W),
      .STRAP_W     (STRAP_W),
      .ADDR_PREFIX (ADDR_PREFIX)
   ) u_match (
      .rx_addr (rx_byte[DATA_W-1:1]),
      .strap   (strap_i),
      .hit     (addr_hit)
   );

   i2c_reg_decode #(
      .DATA_W    (DATA_W),
      .REG_COUNT (REG_COUNT),
      .RO_IDX    (RO_IDX)
   ) u_decode (
      .ptr   (cmd_ptr),
      .sel   (reg_sel_o),
      .rd_ok (ptr_rd_ok),
      .wr_ok (ptr_wr_ok)
   );

   i2c_port_ctrl #(.DATA_W(DATA_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev        (line_ev),
      .addr_hit  (addr_hit),
      .ptr_rd_ok (ptr_rd_ok),
      .ptr_wr_ok (ptr_wr_ok),
      .rd_data   (reg_rdata_i),
      .rx_byte   (rx_byte),
      .ptr_q     (cmd_ptr),
      .rd_stb    (reg_rd_o),
      .wr_stb    (reg_wr_o),
      .sda_low   (sda_drive_low_o)
   );

   assign reg_wdata_o = rx_byte;

endmodule

// File: rtl/i2c_port_target_chk.sv
module i2c_port_target_chk #(
   parameter int DATA_W = 8,
   parameter int SEL_W  = 2,
   parameter int RO_IDX = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_lvl,
   input logic              sda_low,
   input logic              wr,
   input logic              rd,
   input logic [SEL_W-1:0]  sel,
   input logic [DATA_W-1:0] ptr
);

   // R1: the target never moves SDA while SCL stays high
   a_r1_sda_quiet_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_lvl && $past(scl_lvl)) |-> $stable(sda_low));

   // R4: write strobe is a single cycle inside the SCL low phase
   a_r4_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> !wr);
   a_r4_wr_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      wr |-> !scl_lvl);

   // R6: read strobe is a single cycle inside the SCL low phase
   a_r6_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
      rd |=> !rd);
   a_r6_rd_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      rd |-> !scl_lvl);

   // R5: the read-only register never receives a write
   a_r5_no_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
      wr |-> (int'(sel) != RO_IDX));

   // R10: strobes only with an in-range pointer
   a_r10_valid_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      (wr || rd) |-> ((ptr >> SEL_W) == '0));

   // R2: read and write strobes never coincide
   a_r2_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({wr, rd}) <= 1);

endmodule

bind i2c_port_target i2c_port_target_chk #(
   .DATA_W (DATA_W),
   .SEL_W  (SEL_W),
   .RO_IDX (RO_IDX)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .scl_lvl (scl_lvl),
   .sda_low (sda_drive_low_o),
   .wr      (reg_wr_o),
   .rd      (reg_rd_o),
   .sel     (reg_sel_o),
   .ptr     (cmd_ptr)
);

// File: tb/tb_i2c_port_target.sv
module tb_i2c_port_target;

   localparam logic [6:0] MY_ADDR = 7'h25;   // 0100 + straps 101
   localparam logic [7:0] PORT_IN = 8'h96;
   localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_BAD = 2'd2;

   typedef struct packed {
      logic [1:0] kind;
      logic [6:0] addr;
      logic [7:0] cmd;
      logic [7:0] data;
      logic [7:0] exp;   // write: strobe count, read: byte value
   } vec_t;

   localparam int NVEC = 12;
   localparam vec_t VECS [NVEC] = '{
      '{K_WR,  MY_ADDR, 8'h01, 8'h1E, 8'h01},
      '{K_RD,  MY_ADDR, 8'h01, 8'h00, 8'h1E},
      '{K_WR,  MY_ADDR, 8'h02, 8'h35, 8'h01},
      '{K_RD,  MY_ADDR, 8'h02, 8'h00, 8'h35},
      '{K_WR,  MY_ADDR, 8'h03, 8'h0F, 8'h01},
      '{K_RD,  MY_ADDR, 8'h03, 8'h00, 8'h0F},
      '{K_WR,  MY_ADDR, 8'h00, 8'h77, 8'h00},
      '{K_RD,  MY_ADDR, 8'h00, 8'h00, PORT_IN},
      '{K_WR,  MY_ADDR, 8'h81, 8'h55, 8'h00},
      '{K_RD,  MY_ADDR, 8'h05, 8'h00, 8'h00},
      '{K_BAD, 7'h24,   8'h01, 8'hAA, 8'h00},
      '{K_BAD, 7'h65,   8'h01, 8'hAA, 8'h00}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_bus;
   logic [2:0] strap = 3'b101;
   logic       sda_drive_low_o, reg_wr_o, reg_rd_o;
   logic [1:0] reg_sel_o;
   logic [7:0] reg_wdata_o, reg_rdata_i;
   logic [7:0] regs [1:3];
   int         wr_cnt = 0, rd_cnt = 0;
   int         n_chk = 0, n_err = 0;

   always #10 clk = ~clk;

   assign sda_bus = sda_m & ~sda_drive_low_o;
   assign reg_rdata_i = (reg_sel_o == 2'd0) ? PORT_IN : regs[reg_sel_o];

   i2c_port_target dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .scl_i           (scl_m),
      .sda_i           (sda_bus),
      .strap_i         (strap),
      .sda_drive_low_o (sda_drive_low_o),
      .reg_sel_o       (reg_sel_o),
      .reg_wr_o        (reg_wr_o),
      .reg_wdata_o     (reg_wdata_o),
      .reg_rd_o        (reg_rd_o),
      .reg_rdata_i     (reg_rdata_i)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         regs[1] <= 8'hFF;
         regs[2] <= 8'h00;
         regs[3] <= 8'hFF;
      end else begin
         if (reg_wr_o) begin
            if (reg_sel_o != 2'd0) regs[reg_sel_o] <= reg_wdata_o;
            wr_cnt <= wr_cnt + 1;
         end
         if (reg_rd_o) rd_cnt <= rd_cnt + 1;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic hc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; hc(4);
      scl_m = 1'b1; hc(6);
      sda_m = 1'b0; hc(6);
      scl_m = 1'b0; hc(4);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; hc(4);
      scl_m = 1'b1; hc(6);
      sda_m = 1'b1; hc(6);
   endtask

   task automatic put_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; hc(4);
         scl_m = 1'b1; hc(6);
         scl_m = 1'b0; hc(4);
      end
      sda_m = 1'b1; hc(4);
      scl_m = 1'b1; hc(3);
      ack = ~sda_bus;
      hc(3);
      scl_m = 1'b0; hc(4);
   endtask

   task automatic get_byte(input logic give_ack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         hc(4);
         scl_m = 1'b1; hc(3);
         b[i] = sda_bus;
         hc(3);
         scl_m = 1'b0;
      end
      hc(2);
      sda_m = give_ack ? 1'b0 : 1'b1; hc(4);
      scl_m = 1'b1; hc(6);
      scl_m = 1'b0; hc(4);
      sda_m = 1'b1;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      logic       ack;
      logic [7:0] rb;
      int         w0, r0, quiet_bad;

      // R11: reset state
      hc(5);
      check("R11 sda during reset", sda_drive_low_o, 0);
      check("R11 strobes during reset", {reg_wr_o, reg_rd_o}, 0);
      rst_n = 1'b1;
      hc(5);
      check("R11 sda after reset", sda_drive_low_o, 0);
      check("R11 strobes after reset", {reg_wr_o, reg_rd_o}, 0);

      // table walk
      for (int v = 0; v < NVEC; v++) begin
         w0 = wr_cnt;
         r0 = rd_cnt;
         bus_start();
         if (VECS[v].kind == K_BAD) begin
            put_byte({VECS[v].addr, 1'b0}, ack);
            check("R1 foreign address not acked", ack, 0);
            put_byte(VECS[v].cmd, ack);
            put_byte(VECS[v].data, ack);
            bus_stop();
            check("R1 foreign address no strobes", wr_cnt - w0 + rd_cnt - r0, 0);
         end else begin
            put_byte({VECS[v].addr, 1'b0}, ack);
            check("R1 own address acked", ack, 1);
            put_byte(VECS[v].cmd, ack);
            check("R3 command acked", ack, 1);
            if (VECS[v].kind == K_WR) begin
               put_byte(VECS[v].data, ack);
               check("R4/R5/R10 data acked", ack, 1);
               bus_stop();
               check("R4/R5/R10 write strobe count", wr_cnt - w0, VECS[v].exp);
               check("R2 no read strobe in write", rd_cnt - r0, 0);
            end else begin
               bus_start();
               put_byte({VECS[v].addr, 1'b1}, ack);
               check("R2 read address acked", ack, 1);
               get_byte(1'b0, rb);
               bus_stop();
               check("R6 R7 read value", rb, VECS[v].exp);
               check("R6 R10 read strobe count", rd_cnt - r0, (VECS[v].cmd < 8'h04) ? 1 : 0);
            end
         end
      end

      // R4: multi-byte write lands in one register
      w0 = wr_cnt;
      bus_start();
      put_byte({MY_ADDR, 1'b0}, ack);
      put_byte(8'h01, ack);
      put_byte(8'h11, ack);
      put_byte(8'h22, ack);
      put_byte(8'h93, ack);
      check("R4 last data byte acked", ack, 1);
      bus_stop();
      check("R4 three write strobes", wr_cnt - w0, 3);

      // R3 R8: plain read reuses stored pointer, acked bytes repeat the register
      r0 = rd_cnt;
      bus_start();
      put_byte({MY_ADDR, 1'b1}, ack);
      check("R2 direct read acked", ack, 1);
      get_byte(1'b1, rb);
      check("R3 pointer kept after stop", rb, 8'h93);
      get_byte(1'b0, rb);
      check("R8 second byte same register", rb, 8'h93);
      check("R8 one read strobe per byte", rd_cnt - r0, 2);

      // R9: after NACK the target stays silent
      r0 = rd_cnt;
      quiet_bad = 0;
      for (int k = 0; k < 9; k++) begin
         hc(4);
         scl_m = 1'b1; hc(3);
         if (sda_bus !== 1'b1) quiet_bad++;
         hc(3);
         scl_m = 1'b0;
      end
      hc(4);
      check("R9 sda released after nack", quiet_bad, 0);
      check("R9 no strobe after nack", rd_cnt - r0, 0);
      bus_stop();

      // R10: out-of-range pointer, write then read through it
      w0 = wr_cnt;
      r0 = rd_cnt;
      bus_start();
      put_byte({MY_ADDR, 1'b0}, ack);
      put_byte(8'h42, ack);
      check("R10 out-of-range command acked", ack, 1);
      put_byte(8'hC3, ack);
      bus_start();
      put_byte({MY_ADDR, 1'b1}, ack);
      get_byte(1'b0, rb);
      bus_stop();
      check("R10 out-of-range read returns zero", rb, 8'h00);
      check("R10 no strobes", wr_cnt - w0 + rd_cnt - r0, 0);

      summary();
      $finish;
   end

endmodule